// File: doc/BRIEF.md
# Modem Control and Status Register Block

This block holds the control, tone and status registers of a dial-up modem data pump, together with an identification code. A host reaches them in one of two ways. The first is a multiplexed 8-bit address/data bus, where a latch strobe captures the register address and the chip select. The second is a bit-serial command port: it is chosen by holding the latch strobe high and the chip select low, and it moves data least significant bit first on the falling edges of an external shift clock. All pins are sampled by the system clock `clk`, and their edges are found by comparing each sample with the one before it.

The detect register reflects monitor inputs from the receive side and a flag that this block raises itself: the flag is set after a long unbroken run of received marks, which are counted as bit strobes. When a watched detect condition changes, an active-low interrupt request is raised if the interrupt enable in the second control register is set. The request stays active until a read of the detect register completes. The tone generators and modem datapaths that use the control bits are outside this block.

Top module: `modemRegs`

## Requirements
- R1: After reset, both control registers and the tone register read zero. `intN` is high and `adOe` is 0, so nothing is driven onto the bus.
- R2: Parallel mode (`ale` pulsed). The falling edge of `ale` latches `adIn[2:0]` as the address and the level of `csN`. A rising edge of `wrN` writes `adIn` into the addressed register. While `rdN` is low, the register value is driven on `adOut` with `adOe` = 8'hFF.
- R3: If the latched `csN` was high, a write leaves every register unchanged and a read leaves `adOe` at 0.
- R4: Register map: address 0 is control A, 1 is control B, 3 is tone, 2 is detect, 6 is identification. The identification register reads `ID_VALUE` (default 8'h80). Writes to addresses 2 and 6 are ignored. Reads of addresses 4, 5 and 7 return zero.
- R5: Serial mode (`ale` high, `csN` low, address on `serAddr`). Each falling edge of `exclk` while `rdN` is high shifts `adIn[7]` in, least significant bit first. A rising edge of `wrN` then writes the eight collected bits.
- R6: A serial read loads the register at the falling edge of `rdN` and presents bit 0 on `adOut[7]` at once, with `adOe` = 8'h80. Each later falling edge of `exclk` presents the next higher bit.
- R7: The detect register layout is: bit 0 carrier, bit 1 answer tone, bit 2 call progress, bit 3 long loop (`detIn[3:0]`), bit 4 mark-run flag, bit 5 live `rxBit`, bits 7:6 zero. A change in bit 0, 1, 2 or 4 drives `intN` low. A change in bit 3 or bit 5 does not.
- R8: Once low, `intN` stays low until a read of the detect register ends (rising edge of `rdN`). A watched change that arrives in the same cycle as that read end keeps it low.
- R9: When bit 6 of control register B is 0, no detect change drives `intN` low.
- R10: The mark-run flag (detect bit 4) is set on the `MARK_BITS`-th consecutive `rxStrobe` that samples `rxBit` = 1 (default 198). It clears on any strobe that samples `rxBit` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address latch strobe; held high with `csN` low for serial mode |
| csN | input | 1 | Chip select, active low, latched at the `ale` fall |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low; the write takes effect on its rising edge |
| exclk | input | 1 | Serial shift clock, falling-edge active |
| adIn | input | 8 | Bus input: address/data in parallel mode, bit 7 is serial data in |
| adOut | output | 8 | Bus output value |
| adOe | output | 8 | Per-bit output enable for the bus |
| serAddr | input | 3 | Register address in serial mode |
| detIn | input | 4 | Monitor inputs: carrier, answer tone, call progress, long loop |
| rxBit | input | 1 | Received bit before descrambling |
| rxStrobe | input | 1 | One-cycle bit strobe for `rxBit` |
| cr0Out | output | 8 | Control register A contents |
| cr1Out | output | 8 | Control register B contents |
| trOut | output | 8 | Tone register contents |
| intN | output | 1 | Interrupt request, active low (enable for an open-drain driver) |

## Verification
The interesting collision is a read of the detect register that ends in the same system-clock cycle as a new change on a watched detect input. The clear and the set of the interrupt then fall on one edge. The bench provokes this by raising the `rdN` strobe and toggling the call-progress input at the same falling clock edge. It then requires `intN` to stay low, and a second detect read must return the new value and release the request. A similar overlap, where a mark-run strobe lands while the flag is already visible, is judged through the detect read values.

// File: rtl/modemRegs_pkg.sv
package modemRegs_pkg;

  localparam logic [2:0] ADDR_CTLA = 3'd0;
  localparam logic [2:0] ADDR_CTLB = 3'd1;
  localparam logic [2:0] ADDR_DET  = 3'd2;
  localparam logic [2:0] ADDR_TONE = 3'd3;
  localparam logic [2:0] ADDR_ID   = 3'd6;

  // control register B bit that enables the interrupt
  localparam int CTLB_IEN = 6;

  // detect bits whose change raises the interrupt
  localparam logic [7:0] DET_WATCH = 8'b0001_0111;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic       serMode;
    logic       wrEn;
    logic       rdLoad;
    logic       shiftIn;
    logic       shiftOut;
    logic       rdDone;
    logic       drvPar;
    logic       drvSer;
    logic [2:0] addr;
  } regStrb_t;

endpackage

// File: rtl/regCtrl.sv
module regCtrl
  import modemRegs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ale,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic       exclk,
  input  logic [2:0] busAddr,
  input  logic [2:0] serAddr,
  output regStrb_t   strb
);

  logic       aleQ, rdQ, wrQ, exQ;
  logic [2:0] latAddr;
  logic       latSel;

  logic serMode, aleFall, exFall, access;

  always_comb begin
    serMode = ale & ~csN;
    aleFall = aleQ & ~ale;
    exFall  = exQ & ~exclk;
    access  = serMode | latSel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aleQ    <= 1'b0;
      rdQ     <= 1'b1;
      wrQ     <= 1'b1;
      exQ     <= 1'b0;
      latAddr <= '0;
      latSel  <= 1'b0;
    end else begin
      aleQ <= ale;
      rdQ  <= rdN;
      wrQ  <= wrN;
      exQ  <= exclk;
      if (aleFall) begin
        latAddr <= busAddr;
        latSel  <= ~csN;
      end
    end
  end

  always_comb begin
    strb.serMode  = serMode;
    strb.addr     = serMode ? serAddr : latAddr;
    strb.wrEn     = ~wrQ & wrN & access;
    strb.rdDone   = ~rdQ & rdN & access;
    strb.rdLoad   = rdQ & ~rdN & serMode;
    strb.shiftIn  = exFall & rdN & serMode;
    strb.shiftOut = exFall & ~rdN & serMode;
    strb.drvPar   = ~serMode & latSel & ~rdN;
    strb.drvSer   = serMode & ~rdN;
  end

endmodule

// File: rtl/markRun.sv
module markRun #(
  parameter int MARK_BITS = 198
) (
  input  logic clk,
  input  logic rst,
  input  logic rxBit,
  input  logic rxStrobe,
  output logic markFlag
);

  localparam int CW = $clog2(MARK_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(MARK_BITS - 1);

  logic [CW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt   <= '0;
      markFlag <= 1'b0;
    end else if (rxStrobe) begin
      if (!rxBit) begin
        runCnt   <= '0;
        markFlag <= 1'b0;
      end else if (!markFlag) begin
        if (runCnt == LAST) markFlag <= 1'b1;
        else                runCnt   <= runCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/regData.sv
module regData
  import modemRegs_pkg::*;
#(
  parameter logic [7:0] ID_VALUE = 8'h80
) (
  input  logic       clk,
  input  logic       rst,
  input  regStrb_t   strb,
  input  logic [7:0] adIn,
  input  logic [3:0] detIn,
  input  logic       rxBit,
  input  logic       markFlag,
  output logic [7:0] adOut,
  output logic [7:0] adOe,
  output logic [7:0] cr0Out,
  output logic [7:0] cr1Out,
  output logic [7:0] trOut,
  output logic       intN
);

  logic [7:0] ctlA, ctlB, tone, detReg;
  logic [7:0] sIn, sOut;
  logic       intPend;
  logic [7:0] detNow, rdVal, wrData;
  logic       detEvent, detRead;

  always_comb begin
    detNow   = {2'b00, rxBit, markFlag, detIn};
    detEvent = |((detNow ^ detReg) & DET_WATCH) & ctlB[CTLB_IEN];
    detRead  = strb.rdDone & (strb.addr == ADDR_DET);
    wrData   = strb.serMode ? sIn : adIn;
    case (strb.addr)
      ADDR_CTLA: rdVal = ctlA;
      ADDR_CTLB: rdVal = ctlB;
      ADDR_DET:  rdVal = detReg;
      ADDR_TONE: rdVal = tone;
      ADDR_ID:   rdVal = ID_VALUE;
      default:   rdVal = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctlA    <= '0;
      ctlB    <= '0;
      tone    <= '0;
      detReg  <= '0;
      sIn     <= '0;
      sOut    <= '0;
      intPend <= 1'b0;
    end else begin
      detReg  <= detNow;
      // a new event wins over the clear of a completed read
      intPend <= (intPend & ~detRead) | detEvent;
      if (strb.wrEn) begin
        case (strb.addr)
          ADDR_CTLA: ctlA <= wrData;
          ADDR_CTLB: ctlB <= wrData;
          ADDR_TONE: tone <= wrData;
          default: ;
        endcase
      end
      if (strb.shiftIn) sIn <= {adIn[7], sIn[7:1]};
      if (strb.rdLoad)        sOut <= rdVal;
      else if (strb.shiftOut) sOut <= {1'b0, sOut[7:1]};
    end
  end

  always_comb begin
    if (strb.drvSer) begin
      adOut = {sOut[0], 7'b0};
      adOe  = 8'h80;
    end else if (strb.drvPar) begin
      adOut = rdVal;
      adOe  = 8'hFF;
    end else begin
      adOut = 8'h00;
      adOe  = 8'h00;
    end
  end

  assign cr0Out = ctlA;
  assign cr1Out = ctlB;
  assign trOut  = tone;
  assign intN   = ~intPend;

endmodule

// File: rtl/modemRegs.sv
module modemRegs
  import modemRegs_pkg::*;
#(
  parameter logic [7:0] ID_VALUE  = 8'h80,
  parameter int         MARK_BITS = 198
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ale,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic       exclk,
  input  logic [7:0] adIn,
  output logic [7:0] adOut,
  output logic [7:0] adOe,
  input  logic [2:0] serAddr,
  input  logic [3:0] detIn,
  input  logic       rxBit,
  input  logic       rxStrobe,
  output logic [7:0] cr0Out,
  output logic [7:0] cr1Out,
  output logic [7:0] trOut,
  output logic       intN
);

  regStrb_t strb;
  logic     markFlag;

  regCtrl u_ctrl (
    .clk(clk), .rst(rst), .ale(ale), .csN(csN), .rdN(rdN), .wrN(wrN),
    .exclk(exclk), .busAddr(adIn[2:0]), .serAddr(serAddr), .strb(strb)
  );

  markRun #(.MARK_BITS(MARK_BITS)) u_mark (
    .clk(clk), .rst(rst), .rxBit(rxBit), .rxStrobe(rxStrobe),
    .markFlag(markFlag)
  );

  regData #(.ID_VALUE(ID_VALUE)) u_data (
    .clk(clk), .rst(rst), .strb(strb), .adIn(adIn), .detIn(detIn),
    .rxBit(rxBit), .markFlag(markFlag), .adOut(adOut), .adOe(adOe),
    .cr0Out(cr0Out), .cr1Out(cr1Out), .trOut(trOut), .intN(intN)
  );

endmodule

// File: rtl/modemRegs_chk.sv
module modemRegs_chk (
  input logic       clk,
  input logic       rst,
  input logic       rdN,
  input logic       wrN,
  input logic       intN,
  input logic [7:0] adOe,
  input logic [7:0] cr0Out,
  input logic [7:0] cr1Out,
  input logic [7:0] trOut
);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cr0Out == 8'h00 && cr1Out == 8'h00 && trOut == 8'h00 && intN));

  a_r3_no_drive_idle: assert property (@(posedge clk) disable iff (rst)
    rdN |-> adOe == 8'h00);

  a_r5_write_on_wr_rise: assert property (@(posedge clk) disable iff (rst)
    (!$stable(cr0Out) && !$past(rst)) |-> ($past(wrN) && !$past(wrN, 2)));

  a_r8_release_after_read: assert property (@(posedge clk) disable iff (rst)
    $rose(intN) |-> ($past(rdN) && !$past(rdN, 2)));

  a_r9_enable_gates_int: assert property (@(posedge clk) disable iff (rst)
    $fell(intN) |-> $past(cr1Out[6]));

endmodule

bind modemRegs modemRegs_chk u_chk (
  .clk(clk), .rst(rst), .rdN(rdN), .wrN(wrN), .intN(intN), .adOe(adOe),
  .cr0Out(cr0Out), .cr1Out(cr1Out), .trOut(trOut)
);

// File: tb/test_modemRegs.sv
`timescale 1ns/1ps
module test_modemRegs;

  logic       clk = 1'b0;
  logic       rst, ale, csN, rdN, wrN, exclk, rxBit, rxStrobe;
  logic [7:0] adIn, adOut, adOe, cr0Out, cr1Out, trOut;
  logic [2:0] serAddr;
  logic [3:0] detIn;
  logic       intN;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  done    = 0;
  logic [7:0] mA, mB, mT, rv, oe;

  always #2 clk = ~clk;

  modemRegs i_modemRegs (
    .clk(clk), .rst(rst), .ale(ale), .csN(csN), .rdN(rdN), .wrN(wrN),
    .exclk(exclk), .adIn(adIn), .adOut(adOut), .adOe(adOe),
    .serAddr(serAddr), .detIn(detIn), .rxBit(rxBit), .rxStrobe(rxStrobe),
    .cr0Out(cr0Out), .cr1Out(cr1Out), .trOut(trOut), .intN(intN)
  );

  // {address, write data, csN, expected read}
  localparam logic [19:0] VEC [8] = '{
    {3'd0, 8'hA5, 1'b0, 8'hA5},
    {3'd1, 8'h3C, 1'b0, 8'h3C},
    {3'd3, 8'h5A, 1'b0, 8'h5A},
    {3'd0, 8'hFF, 1'b1, 8'h00},
    {3'd2, 8'hFF, 1'b0, 8'h00},
    {3'd6, 8'h00, 1'b0, 8'h80},
    {3'd5, 8'h77, 1'b0, 8'h00},
    {3'd1, 8'h00, 1'b0, 8'h00}
  };

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic parWrite(input logic [2:0] a, input logic [7:0] d, input logic c);
    ale = 1'b1; adIn = {5'b0, a}; csN = c; step();
    ale = 1'b0; step();
    csN = 1'b1; adIn = d; wrN = 1'b0; step();
    wrN = 1'b1; step(2);
  endtask

  task automatic parRead(input logic [2:0] a, input logic c,
                         output logic [7:0] v, output logic [7:0] e);
    ale = 1'b1; adIn = {5'b0, a}; csN = c; step();
    ale = 1'b0; step();
    csN = 1'b1; adIn = 8'h00; rdN = 1'b0; step();
    v = adOut; e = adOe;
    rdN = 1'b1; step(2);
  endtask

  task automatic serWrite(input logic [2:0] a, input logic [7:0] d);
    serAddr = a;
    for (int i = 0; i < 8; i++) begin
      adIn[7] = d[i]; exclk = 1'b1; step();
      exclk = 1'b0; step();
    end
    wrN = 1'b0; step();
    wrN = 1'b1; step(2);
  endtask

  task automatic serRead(input logic [2:0] a, output logic [7:0] v, output logic [7:0] e);
    serAddr = a;
    rdN = 1'b0; step();
    v[0] = adOut[7]; e = adOe;
    for (int i = 1; i < 8; i++) begin
      exclk = 1'b1; step();
      exclk = 1'b0; step();
      v[i] = adOut[7];
    end
    rdN = 1'b1; step(2);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      rxStrobe = 1'b1; step();
      rxStrobe = 1'b0; step();
    end
  endtask

  function automatic logic [7:0] detExp();
    return {2'b00, rxBit, 1'b0, detIn};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ale = 1'b0; csN = 1'b1; rdN = 1'b1; wrN = 1'b1; exclk = 1'b0;
    adIn = 8'h00; serAddr = 3'd0; detIn = 4'h0; rxBit = 1'b0; rxStrobe = 1'b0;
    mA = 8'h00; mB = 8'h00; mT = 8'h00;
    step(3);
    rst = 1'b0;
    step();
    chk("R1 ctlA", cr0Out, 8'h00);
    chk("R1 ctlB", cr1Out, 8'h00);
    chk("R1 tone", trOut, 8'h00);
    chk("R1 intN", {7'b0, intN}, 8'h01);
    chk("R1 adOe", adOe, 8'h00);

    // R2 R3 R4: parallel table
    for (int i = 0; i < 8; i++) begin
      logic [2:0] a;
      logic [7:0] d, x;
      logic       c;
      {a, d, c, x} = VEC[i];
      parWrite(a, d, c);
      if (!c) begin
        if (a == 3'd0) mA = d;
        if (a == 3'd1) mB = d;
        if (a == 3'd3) mT = d;
      end
      chk("R2/R3 ctlA after write", cr0Out, mA);
      chk("R2/R3 ctlB after write", cr1Out, mB);
      chk("R2/R4 tone after write", trOut, mT);
      parRead(a, c, rv, oe);
      if (c) chk("R3 no drive when deselected", oe, 8'h00);
      else begin
        chk("R2/R4 read value", rv, x);
        chk("R2 drive enable", oe, 8'hFF);
      end
    end

    // R5 R6: serial port
    ale = 1'b1; csN = 1'b0; step();
    serWrite(3'd0, 8'h96);
    chk("R5 serial write ctlA", cr0Out, 8'h96);
    serWrite(3'd3, 8'h0F);
    chk("R5 serial write tone", trOut, 8'h0F);
    serWrite(3'd2, 8'hFF);
    serRead(3'd2, rv, oe);
    chk("R4 serial detect unchanged", rv, 8'h00);
    serRead(3'd6, rv, oe);
    chk("R6 serial read id", rv, 8'h80);
    chk("R6 serial drive enable", oe, 8'h80);
    serRead(3'd0, rv, oe);
    chk("R6 serial read ctlA", rv, 8'h96);
    ale = 1'b0; step();
    csN = 1'b1; step();

    // R7 R8: interrupt
    parWrite(3'd1, 8'h40, 1'b0);
    detIn[0] = 1'b1; step(2);
    chk("R7 carrier change", {7'b0, intN}, 8'h00);
    step(5);
    chk("R8 stays low", {7'b0, intN}, 8'h00);
    parRead(3'd2, 1'b0, rv, oe);
    chk("R7 detect layout", rv, 8'h01);
    chk("R8 released by read", {7'b0, intN}, 8'h01);
    detIn[3] = 1'b1; step(3);
    chk("R7 long loop ignored", {7'b0, intN}, 8'h01);
    rxBit = 1'b1; step(3);
    chk("R7 rx bit ignored", {7'b0, intN}, 8'h01);
    rxBit = 1'b0; step(3);

    // R8 collision: read end and new change on one edge
    detIn[1] = 1'b1; step(2);
    chk("R8 answer tone change", {7'b0, intN}, 8'h00);
    ale = 1'b1; adIn = 8'h02; csN = 1'b0; step();
    ale = 1'b0; step();
    csN = 1'b1; adIn = 8'h00; rdN = 1'b0; step();
    chk("R8 read before collision", adOut, 8'h0B);
    rdN = 1'b1; detIn[2] = 1'b1; step(2);
    chk("R8 collision keeps request", {7'b0, intN}, 8'h00);
    parRead(3'd2, 1'b0, rv, oe);
    chk("R8 read after collision", rv, 8'h0F);
    chk("R8 released after collision", {7'b0, intN}, 8'h01);

    // R9: enable off
    parWrite(3'd1, 8'h00, 1'b0);
    detIn[0] = 1'b0; step(3);
    chk("R9 disabled no request", {7'b0, intN}, 8'h01);
    parWrite(3'd1, 8'h40, 1'b0);
    step(2);
    chk("R9 re-enable no stale request", {7'b0, intN}, 8'h01);

    // R10: mark run
    rxBit = 1'b1; step(2);
    pulse(197);
    step(2);
    chk("R10 no flag before limit", {7'b0, intN}, 8'h01);
    parRead(3'd2, 1'b0, rv, oe);
    chk("R10 detect before limit", rv, detExp());
    pulse(1);
    step(2);
    chk("R10 flag raises request", {7'b0, intN}, 8'h00);
    parRead(3'd2, 1'b0, rv, oe);
    chk("R10 flag visible", rv, detExp() | 8'h10);
    rxBit = 1'b0;
    pulse(1);
    step(2);
    chk("R10 flag drop raises request", {7'b0, intN}, 8'h00);
    parRead(3'd2, 1'b0, rv, oe);
    chk("R10 flag cleared", rv, detExp());
    rxBit = 1'b1; pulse(100);
    rxBit = 1'b0; pulse(1);
    rxBit = 1'b1; pulse(197);
    step(2);
    parRead(3'd2, 1'b0, rv, oe);
    chk("R10 broken run no flag", rv, detExp());
    chk("R10 broken run no request", {7'b0, intN}, 8'h01);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule